// File: doc/BRIEF.md
# Radix-4 Tree Carry-Lookahead Adder

This block adds two unsigned operands of parameterised width and a carry-in, and produces the sum, the carry-out, and the propagate/generate pair that describes the whole operand width. It has no clock and no state. Results follow the inputs within one combinational settling time.

Each bit first forms a propagate (a XOR b) and a generate (a AND b). A 4-input lookahead node merges four propagate/generate pairs into one group pair. Nodes are stacked as a 4-ary tree, so a width of 4^L needs L node levels. The top pair is exported. Carries travel the other way. The carry-in enters at the root. Each node turns its incoming carry and the pairs of its lower three children into the carries for its four children, and these carries reach the bit level, where each sum bit is formed.

The exported group pair lets a larger adder use this block as one lookahead group.

Top module: `cla4_tree_adder`

## Requirements
- R1: For every operand pair and carry-in, `{cout_o, sum_o}` equals the unsigned value a_i + b_i + cin_i, computed in WIDTH+1 bits.
- R2: Bit i of the sum equals (a_i[i] XOR b_i[i]) XOR (carry into bit i). With a_i equal to b_i, no bit propagates, and the sum is therefore a_i shifted left by one with cin_i in bit 0.
- R3: `grp_g_o` is 1 exactly when a_i + b_i (carry-in excluded) is 2^WIDTH or more. When `grp_g_o` is 1, `cout_o` is 1 for both values of cin_i.
- R4: `grp_p_o` is 1 exactly when every bit of a_i XOR b_i is 1.
- R5: `cout_o` equals `grp_g_o` OR (`grp_p_o` AND cin_i). When `grp_p_o` is 1 (for example with b_i = ~a_i), `cout_o` equals cin_i and the sum is all ones when cin_i is 0 and all zeros when cin_i is 1.
- R6: `grp_p_o` and `grp_g_o` are never both 1, and the same holds for the pair of every internal node.
- R7: A carry that starts in bit 0 crosses every 4-bit group boundary and every higher-level group boundary. With a_i = 2^k - 1, b_i = 1 and cin_i = 0, the sum is 2^k and `cout_o` is 0 for k < WIDTH. For k = WIDTH the sum is 0 and `cout_o` is 1.
- R8: WIDTH is a power of four and at least 4 (default 16). R1 to R7 hold at widths 4, 16 and 64.
- R9: The block is purely combinational. Outputs reflect inputs that were changed during the same clock cycle, without waiting for any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry out of the top bit |
| grp_p_o | output | 1 | Propagate over the full width |
| grp_g_o | output | 1 | Generate over the full width |

## Verification
The hardest case to reach is a carry that enters at the root and must run through every tree level. This needs full-width propagation, and random operands almost never produce it: at 64 bits the chance is 2^-64. Directed vectors set b to the complement of a for both carry-in values. They also use a = 2^k - 1 with b = 1 so that a carry ripples across the 4-, 16- and 64-bit boundaries. The 4-bit instance is driven through all 512 input combinations. The 16- and 64-bit instances receive seeded random operands alongside these corners.

// File: rtl/cla4_pkg.sv
package cla4_pkg;

    typedef struct packed {
        logic p;
        logic g;
    } pg_t;

    // number of 4-ary levels above the bits
    function automatic int tree_levels(input int width);
        int n;
        int lv;
        n  = width;
        lv = 0;
        while (n > 1) begin
            n  = n / 4;
            lv = lv + 1;
        end
        return lv;
    endfunction

    // start index of level lv inside the flattened node array
    function automatic int level_base(input int width, input int lv);
        int base;
        base = 0;
        for (int k = 0; k < lv; k++) begin
            base = base + (width >> (2 * k));
        end
        return base;
    endfunction

endpackage

// File: rtl/cla4_bit_pg.sv
module cla4_bit_pg
    import cla4_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output pg_t  [WIDTH-1:0] pg_o
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign pg_o[i].p = a_i[i] ^ b_i[i];
        assign pg_o[i].g = a_i[i] & b_i[i];
    end

endmodule

// File: rtl/cla4_node.sv
module cla4_node
    import cla4_pkg::*;
(
    input  pg_t  [3:0] sub_i,
    input  logic       cin_i,
    output pg_t        grp_o,
    output logic [3:0] c_o
);

    logic [3:0] p;
    logic [3:0] g;
    logic       ripple_out;

    always_comb begin
        for (int i = 0; i < 4; i++) begin
            p[i] = sub_i[i].p;
            g[i] = sub_i[i].g;
        end

        c_o[0] = cin_i;
        c_o[1] = g[0] | (p[0] & cin_i);
        c_o[2] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & cin_i);
        c_o[3] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0])
               | (p[2] & p[1] & p[0] & cin_i);

        grp_o.p = &p;
        grp_o.g = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1])
                | (p[3] & p[2] & p[1] & g[0]);

        // carry leaving the last child, stepped from the distributed carry
        ripple_out = g[3] | (p[3] & c_o[3]);
    end

    always_comb begin
        if (!$isunknown({sub_i, cin_i})) begin
            // R5
            grp_pass_chk: assert (!grp_o.p || (ripple_out == cin_i));
            // R3
            grp_force_chk: assert (!grp_o.g || ripple_out);
            // R6
            grp_excl_chk: assert (!(grp_o.p && grp_o.g));
        end
    end

endmodule

// File: rtl/cla4_sum_xor.sv
module cla4_sum_xor
    import cla4_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  pg_t  [WIDTH-1:0] pg_i,
    input  logic [WIDTH-1:0] carry_i,
    output logic [WIDTH-1:0] sum_o
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_sum
        assign sum_o[i] = pg_i[i].p ^ carry_i[i];
    end

endmodule

// File: rtl/cla4_tree_adder.sv
module cla4_tree_adder
    import cla4_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic             grp_p_o,
    output logic             grp_g_o
);

    localparam int LEVELS = tree_levels(WIDTH);
    localparam int TOTAL  = level_base(WIDTH, LEVELS + 1);
    localparam int ROOT   = TOTAL - 1;

    pg_t  [WIDTH-1:0] bit_pg;
    logic [WIDTH-1:0] bit_carry;
    pg_t              pg_all [TOTAL];
    logic             c_all  [TOTAL];

    cla4_bit_pg #(.WIDTH(WIDTH)) u_bit_pg (
        .a_i  (a_i),
        .b_i  (b_i),
        .pg_o (bit_pg)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_leaf
        assign pg_all[i]    = bit_pg[i];
        assign bit_carry[i] = c_all[i];
    end

    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
        localparam int LO_BASE = level_base(WIDTH, lv);
        localparam int HI_BASE = level_base(WIDTH, lv + 1);
        localparam int NODES   = WIDTH >> (2 * (lv + 1));
        for (genvar j = 0; j < NODES; j++) begin : g_node
            pg_t  [3:0] sub;
            logic [3:0] cdown;
            for (genvar k = 0; k < 4; k++) begin : g_child
                assign sub[k]                     = pg_all[LO_BASE + 4 * j + k];
                assign c_all[LO_BASE + 4 * j + k] = cdown[k];
            end
            cla4_node u_node (
                .sub_i (sub),
                .cin_i (c_all[HI_BASE + j]),
                .grp_o (pg_all[HI_BASE + j]),
                .c_o   (cdown)
            );
        end
    end

    assign c_all[ROOT] = cin_i;

    cla4_sum_xor #(.WIDTH(WIDTH)) u_sum (
        .pg_i    (bit_pg),
        .carry_i (bit_carry),
        .sum_o   (sum_o)
    );

    assign grp_p_o = pg_all[ROOT].p;
    assign grp_g_o = pg_all[ROOT].g;
    assign cout_o  = pg_all[ROOT].g | (pg_all[ROOT].p & cin_i);

    always_comb begin
        if (!$isunknown({a_i, b_i, cin_i})) begin
            // R1
            add_value_chk: assert ({cout_o, sum_o} ==
                ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}));
            // R6
            top_excl_chk: assert (!(grp_p_o && grp_g_o));
        end
    end

endmodule

// File: tb/cla4_tree_adder_bench.sv
module cla4_tree_adder_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    logic [3:0]  a4, b4, s4;
    logic [15:0] a16, b16, s16;
    logic [63:0] a64, b64, s64;
    logic        c4, c16, c64;
    logic        co4, co16, co64, p4, p16, p64, g4, g16, g64;

    cla4_tree_adder #(.WIDTH(4)) u_cla4_tree_adder_w4 (
        .a_i(a4), .b_i(b4), .cin_i(c4), .sum_o(s4), .cout_o(co4),
        .grp_p_o(p4), .grp_g_o(g4));
    cla4_tree_adder u_cla4_tree_adder (
        .a_i(a16), .b_i(b16), .cin_i(c16), .sum_o(s16), .cout_o(co16),
        .grp_p_o(p16), .grp_g_o(g16));
    cla4_tree_adder #(.WIDTH(64)) u_cla4_tree_adder_w64 (
        .a_i(a64), .b_i(b64), .cin_i(c64), .sum_o(s64), .cout_o(co64),
        .grp_p_o(p64), .grp_g_o(g64));

    function automatic logic [66:0] ref_add(input logic [66:0] a, input logic [66:0] b,
                                            input logic c, input int n);
        logic [66:0] r;
        r = a + b + {66'd0, c};
        return r & ((67'd1 << (n + 1)) - 67'd1);
    endfunction

    function automatic logic ref_gen(input logic [66:0] a, input logic [66:0] b, input int n);
        logic [66:0] r;
        r = a + b;
        return r[n];
    endfunction

    function automatic logic ref_prop(input logic [66:0] a, input logic [66:0] b, input int n);
        logic [66:0] m;
        m = (67'd1 << n) - 67'd1;
        return ((a ^ b) & m) == m;
    endfunction

    task automatic check(input string tag, input logic [66:0] got, input logic [66:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check({tag, " R1 w4 sum"},  {62'd0, co4, s4},  ref_add({63'd0, a4}, {63'd0, b4}, c4, 4));
        check({tag, " R1 w16 sum"}, {50'd0, co16, s16}, ref_add({51'd0, a16}, {51'd0, b16}, c16, 16));
        check({tag, " R1 w64 sum"}, {2'd0, co64, s64},  ref_add({3'd0, a64}, {3'd0, b64}, c64, 64));
        check({tag, " R3 w4 gen"},  {66'd0, g4},  {66'd0, ref_gen({63'd0, a4}, {63'd0, b4}, 4)});
        check({tag, " R3 w16 gen"}, {66'd0, g16}, {66'd0, ref_gen({51'd0, a16}, {51'd0, b16}, 16)});
        check({tag, " R3 w64 gen"}, {66'd0, g64}, {66'd0, ref_gen({3'd0, a64}, {3'd0, b64}, 64)});
        check({tag, " R4 w4 prop"},  {66'd0, p4},  {66'd0, ref_prop({63'd0, a4}, {63'd0, b4}, 4)});
        check({tag, " R4 w16 prop"}, {66'd0, p16}, {66'd0, ref_prop({51'd0, a16}, {51'd0, b16}, 16)});
        check({tag, " R4 w64 prop"}, {66'd0, p64}, {66'd0, ref_prop({3'd0, a64}, {3'd0, b64}, 64)});
        check({tag, " R6 excl"}, {64'd0, p4 & g4, p16 & g16, p64 & g64}, 67'd0);
    endtask

    task automatic apply(input logic [3:0] xa4, input logic [3:0] xb4, input logic xc4,
                         input logic [15:0] xa16, input logic [15:0] xb16, input logic xc16,
                         input logic [63:0] xa64, input logic [63:0] xb64, input logic xc64,
                         input string tag);
        @(posedge clk);
        #0.5;
        a4 = xa4;   b4 = xb4;   c4 = xc4;
        a16 = xa16; b16 = xb16; c16 = xc16;
        a64 = xa64; b64 = xb64; c64 = xc64;
        @(negedge clk);
        check_all(tag);
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        a4 = '0; b4 = '0; c4 = 1'b0;
        a16 = '0; b16 = '0; c16 = 1'b0;
        a64 = '0; b64 = '0; c64 = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("reset zero inputs R1 sum", {50'd0, co16, s16}, 67'd0);
        check("reset zero inputs R4 prop", {64'd0, p4, p16, p64}, 67'd0);

        // R8: exhaustive 4-bit, random 16/64-bit alongside
        for (int v = 0; v < 512; v++) begin
            apply(v[3:0], v[7:4], v[8], 16'($urandom), 16'($urandom), 1'($urandom),
                  rnd64(), rnd64(), 1'($urandom), "R8 sweep");
        end

        // R5: full-length propagate, both carry-in values
        for (int c = 0; c < 2; c++) begin
            logic [63:0] r;
            r = rnd64();
            apply(r[3:0], ~r[3:0], c[0], r[15:0], ~r[15:0], c[0], r, ~r, c[0], "R5 prop");
            check("R5 cout follows cin", {64'd0, co4, co16, co64}, {64'd0, {3{c[0]}}});
            check("R5 w64 sum", {3'd0, s64}, c[0] ? 67'd0 : {3'd0, {64{1'b1}}});
        end

        // R2: equal operands, no bit propagates
        for (int c = 0; c < 2; c++) begin
            logic [63:0] r;
            r = rnd64();
            apply(r[3:0], r[3:0], c[0], r[15:0], r[15:0], c[0], r, r, c[0], "R2 equal");
            check("R2 w64 shifted", {2'd0, co64, s64}, {2'd0, r, c[0]});
            check("R2 w16 shifted", {50'd0, co16, s16}, {50'd0, r[15:0], c[0]});
        end

        // R7: carry chain across group boundaries
        for (int k = 1; k <= 64; k++) begin
            logic [63:0] ones;
            ones = (k == 64) ? {64{1'b1}} : ((64'd1 << k) - 64'd1);
            apply(ones[3:0], 4'd1, 1'b0, ones[15:0], 16'd1, 1'b0, ones, 64'd1, 1'b0, "R7 chain");
            check("R7 w64 chain", {2'd0, co64, s64}, 67'd1 << k);
            if (k <= 16) check("R7 w16 chain", {50'd0, co16, s16}, 67'd1 << k);
        end

        // R3: forced generate makes cout 1 for both carry-in values
        apply(4'h8, 4'h8, 1'b0, 16'h8000, 16'h8000, 1'b0, 64'h8000_0000_0000_0000,
              64'h8000_0000_0000_0000, 1'b0, "R3 msb");
        check("R3 cout cin0", {64'd0, co4, co16, co64}, 67'd7);
        apply(4'h8, 4'h8, 1'b1, 16'h8000, 16'h8000, 1'b1, 64'h8000_0000_0000_0000,
              64'h8000_0000_0000_0000, 1'b1, "R3 msb");
        check("R3 cout cin1", {64'd0, co4, co16, co64}, 67'd7);

        // R9: inputs change mid-cycle, outputs follow before the next edge
        @(posedge clk);
        #0.5;
        a16 = 16'hFFFF; b16 = 16'h0000; c16 = 1'b1;
        #1;
        check("R9 same cycle", {50'd0, co16, s16}, 67'h1_0000);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule